// File: doc/BRIEF.md
# Macropixel Sparsified Hit Readout Controller

This block is the periphery logic of a pixel matrix whose pixels are grouped into 4x4 macropixels. Each macropixel has two private wires: a hit flag towards the controller and a readout enable from it. All macropixels share four row data lines, a four-wide column select and one latch-clear line. When a hit flag rises, the controller marks the macropixel as pending and stores the current value of a free-running timestamp counter for it. Only after that does it enable the macropixel.

Pending macropixels are served one at a time, lowest index first. The controller walks through the four columns of the enabled macropixel. It reads the four shared row bits of each column and sends one word per hit pixel on a valid/ready output bus. Empty pixels produce no word. After the last column it pulses the shared clear so the enabled macropixel resets its latches. It then releases the enable and the pending flag and moves on to the next pending macropixel.

The default build has 16 macropixels (a 16x16 pixel matrix). The macropixel count is a parameter, so a 4k-pixel matrix uses 256.

Top module: `mpix_readout_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every readout enable, the column select, the clear line and the output valid are all low.
- R2: An 8-bit timestamp counter is 0 during reset and increments on every clock edge after reset. A rising hit flag on a macropixel that is not pending stores the counter value of the edge on which the rise is first sampled.
- R3: A macropixel's readout enable rises on the clock edge after the one that registered its pending state. At most one enable is high at any time, and only for a pending macropixel.
- R4: When several macropixels are pending while the controller is idle, the lowest-indexed one is served first.
- R5: A hit flag rise on a macropixel that is already pending is merged into the existing entry. The stored timestamp is kept and the macropixel is read out only once.
- R6: Columns are scanned in order 0, 1, 2, 3, with exactly one column-select bit high (bit c selects column c). With ready held high, each column takes max(1, number of hit rows) cycles, and the enable stays high for the sum over the four columns plus one clear cycle.
- R7: One word is emitted per set row bit (row bit r is row r), in ascending row order within a column. A macropixel whose columns all read zero emits no words.
- R8: The output word is {macropixel index [15:12], column [11:10], row [9:8], stored timestamp [7:0]}.
- R9: While valid is high and ready is low, valid stays high, the word stays unchanged and the scan does not advance.
- R10: After the last column, the clear line is high for exactly one cycle with the enable still high and no column selected. The enable and the pending flag then drop, and a later hit on the same macropixel is captured with a fresh timestamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mp_hit_i | input | N_MP | Per-macropixel hit flags |
| mp_rd_en_o | output | N_MP | Per-macropixel readout enables |
| col_sel_o | output | 4 | Shared one-hot column select |
| pix_row_i | input | 4 | Shared row data from the enabled macropixel |
| pix_clr_o | output | 1 | Shared latch clear, honoured by the enabled macropixel |
| word_valid_o | output | 1 | Output word valid |
| word_ready_i | input | 1 | Output word accepted |
| word_data_o | output | WORD_W | Formatted hit word |

## Verification
The hardest case to reach is a merged hit. A flag must rise again on a macropixel that is already pending but not yet served, which only happens while the scanner is busy elsewhere. The bench holds ready low so a lower macropixel stalls mid-scan. It then raises, drops and raises again the flag of a waiting macropixel, adding pixels on the second rise. The expected stream shows a single readout holding the union of pixels under the first timestamp. The same stall is used to queue macropixels out of index order, which checks the priority.

// File: rtl/mpix_pkg.sv
package mpix_pkg;
    localparam int COLS   = 4;
    localparam int ROWS   = 4;
    localparam int CIDX_W = $clog2(COLS);
    localparam int RIDX_W = $clog2(ROWS);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_CLR  = 2'd2
    } scan_st_e;
endpackage

// File: rtl/mpix_hit_capture.sv
module mpix_hit_capture #(
    parameter int N_MP = 16,
    parameter int TS_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_MP-1:0]                hit_i,
    input  logic [N_MP-1:0]                release_i,
    input  logic [TS_W-1:0]                ts_now_i,
    output logic [N_MP-1:0]                pend_o,
    output logic [N_MP-1:0][TS_W-1:0]      ts_o
);
    typedef struct packed {
        logic [N_MP-1:0]           hit_prev;
        logic [N_MP-1:0]           pend;
        logic [N_MP-1:0][TS_W-1:0] ts;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [N_MP-1:0] rise;

    always_comb begin
        cap_d          = cap_q;
        rise           = hit_i & ~cap_q.hit_prev;
        cap_d.hit_prev = hit_i;
        for (int i = 0; i < N_MP; i++) begin
            if (rise[i] && !cap_q.pend[i]) begin
                cap_d.pend[i] = 1'b1;
                cap_d.ts[i]   = ts_now_i;
            end
        end
        // a rise in the release cycle is absorbed by the entry being retired
        cap_d.pend = cap_d.pend & ~release_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign pend_o = cap_q.pend;
    assign ts_o   = cap_q.ts;
endmodule

// File: rtl/mpix_prio_pick.sv
module mpix_prio_pick #(
    parameter int N_MP = 16,
    localparam int MP_W = (N_MP > 1) ? $clog2(N_MP) : 1
) (
    input  logic [N_MP-1:0] req_i,
    output logic            any_o,
    output logic [MP_W-1:0] idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = N_MP - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = MP_W'(i);
        end
    end
endmodule

// File: rtl/mpix_col_scan.sv
module mpix_col_scan
    import mpix_pkg::*;
#(
    parameter int N_MP = 16,
    parameter int TS_W = 8,
    localparam int MP_W   = (N_MP > 1) ? $clog2(N_MP) : 1,
    localparam int WORD_W = MP_W + CIDX_W + RIDX_W + TS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_any_i,
    input  logic [MP_W-1:0]   pick_idx_i,
    input  logic [TS_W-1:0]   ts_i,
    input  logic [ROWS-1:0]   row_bits_i,
    input  logic              ready_i,
    output logic [MP_W-1:0]   idx_o,
    output logic [N_MP-1:0]   rd_en_o,
    output logic [COLS-1:0]   col_sel_o,
    output logic              clr_o,
    output logic [N_MP-1:0]   release_o,
    output logic              valid_o,
    output logic [WORD_W-1:0] word_o
);
    typedef struct packed {
        scan_st_e          st;
        logic [MP_W-1:0]   idx;
        logic [CIDX_W-1:0] col;
        logic [ROWS-1:0]   taken;
    } scan_t;

    scan_t scan_d, scan_q;
    logic [ROWS-1:0]   avail;
    logic [ROWS-1:0]   pick;
    logic [RIDX_W-1:0] row;
    logic              last_col;
    logic [N_MP-1:0]   mp_onehot;

    always_comb begin
        avail = row_bits_i & ~scan_q.taken;
        row   = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (avail[r]) row = RIDX_W'(r);
        end
        pick     = ROWS'(1) << row;
        last_col = (scan_q.col == CIDX_W'(COLS - 1));

        scan_d = scan_q;
        unique case (scan_q.st)
            ST_IDLE: begin
                if (pend_any_i) begin
                    scan_d.st    = ST_SCAN;
                    scan_d.idx   = pick_idx_i;
                    scan_d.col   = '0;
                    scan_d.taken = '0;
                end
            end
            ST_SCAN: begin
                if (!(|avail) || (ready_i && ((avail & ~pick) == '0))) begin
                    scan_d.taken = '0;
                    if (last_col) scan_d.st  = ST_CLR;
                    else          scan_d.col = scan_q.col + CIDX_W'(1);
                end else if (ready_i) begin
                    scan_d.taken = scan_q.taken | pick;
                end
            end
            ST_CLR:  scan_d.st = ST_IDLE;
            default: scan_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) scan_q <= '{st: ST_IDLE, idx: '0, col: '0, taken: '0};
        else        scan_q <= scan_d;
    end

    assign mp_onehot = N_MP'(1) << scan_q.idx;
    assign idx_o     = scan_q.idx;
    assign rd_en_o   = (scan_q.st != ST_IDLE) ? mp_onehot : '0;
    assign col_sel_o = (scan_q.st == ST_SCAN) ? (COLS'(1) << scan_q.col) : '0;
    assign clr_o     = (scan_q.st == ST_CLR);
    assign release_o = (scan_q.st == ST_CLR) ? mp_onehot : '0;
    assign valid_o   = (scan_q.st == ST_SCAN) && (|avail);
    assign word_o    = {scan_q.idx, scan_q.col, row, ts_i};
endmodule

// File: rtl/mpix_readout_ctrl.sv
module mpix_readout_ctrl
    import mpix_pkg::*;
#(
    parameter int N_MP = 16,
    parameter int TS_W = 8,
    localparam int MP_W   = (N_MP > 1) ? $clog2(N_MP) : 1,
    localparam int WORD_W = MP_W + CIDX_W + RIDX_W + TS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_MP-1:0]   mp_hit_i,
    output logic [N_MP-1:0]   mp_rd_en_o,
    output logic [COLS-1:0]   col_sel_o,
    input  logic [ROWS-1:0]   pix_row_i,
    output logic              pix_clr_o,
    output logic              word_valid_o,
    input  logic              word_ready_i,
    output logic [WORD_W-1:0] word_data_o
);
    typedef struct packed {
        logic [TS_W-1:0] ts;
    } top_t;

    top_t top_d, top_q;

    logic [N_MP-1:0]           pend_w;
    logic [N_MP-1:0]           release_w;
    logic [N_MP-1:0][TS_W-1:0] ts_arr;
    logic                      pend_any;
    logic [MP_W-1:0]           pick_idx;
    logic [MP_W-1:0]           scan_idx;

    always_comb begin
        top_d    = top_q;
        top_d.ts = top_q.ts + TS_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    mpix_hit_capture #(.N_MP(N_MP), .TS_W(TS_W)) cap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (mp_hit_i),
        .release_i (release_w),
        .ts_now_i  (top_q.ts),
        .pend_o    (pend_w),
        .ts_o      (ts_arr)
    );

    mpix_prio_pick #(.N_MP(N_MP)) pick_i (
        .req_i (pend_w),
        .any_o (pend_any),
        .idx_o (pick_idx)
    );

    mpix_col_scan #(.N_MP(N_MP), .TS_W(TS_W)) scan_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_any_i (pend_any),
        .pick_idx_i (pick_idx),
        .ts_i       (ts_arr[scan_idx]),
        .row_bits_i (pix_row_i),
        .ready_i    (word_ready_i),
        .idx_o      (scan_idx),
        .rd_en_o    (mp_rd_en_o),
        .col_sel_o  (col_sel_o),
        .clr_o      (pix_clr_o),
        .release_o  (release_w),
        .valid_o    (word_valid_o),
        .word_o     (word_data_o)
    );
endmodule

// File: rtl/mpix_readout_chk.sv
module mpix_readout_chk #(
    parameter int N_MP = 16,
    parameter int TS_W = 8,
    localparam int MP_W   = (N_MP > 1) ? $clog2(N_MP) : 1,
    localparam int WORD_W = MP_W + 4 + TS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_MP-1:0]   mp_rd_en_o,
    input logic [3:0]        col_sel_o,
    input logic              pix_clr_o,
    input logic              word_valid_o,
    input logic              word_ready_i,
    input logic [WORD_W-1:0] word_data_o,
    input logic [N_MP-1:0]   pend_i
);
    a_r3_single_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mp_rd_en_o));

    a_r3_enable_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (mp_rd_en_o & ~pend_i) == '0);

    a_r6_col_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_sel_o));

    a_r6_col_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (col_sel_o != '0) |-> (mp_rd_en_o != '0));

    a_r8_word_matches_enable: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_o |-> mp_rd_en_o[word_data_o[WORD_W-1 -: MP_W]]);

    a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_o && !word_ready_i) |=> (word_valid_o && $stable(word_data_o)));

    a_r10_clear_with_enable: assert property (@(posedge clk) disable iff (!rst_n)
        pix_clr_o |-> ((mp_rd_en_o != '0) && (col_sel_o == '0) && !word_valid_o));

    a_r10_enable_drops_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        pix_clr_o |=> (mp_rd_en_o == '0));
endmodule

bind mpix_readout_ctrl mpix_readout_chk #(.N_MP(N_MP), .TS_W(TS_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .mp_rd_en_o   (mp_rd_en_o),
    .col_sel_o    (col_sel_o),
    .pix_clr_o    (pix_clr_o),
    .word_valid_o (word_valid_o),
    .word_ready_i (word_ready_i),
    .word_data_o  (word_data_o),
    .pend_i       (pend_w)
);

// File: tb/mpix_readout_ctrl_tb_top.sv
`timescale 1ns/1ps
module mpix_readout_ctrl_tb_top;
    localparam int NM = 16;
    localparam int TW = 8;
    localparam int WW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NM-1:0] rd_en;
    logic [3:0]    col_sel;
    logic [3:0]    pix_row;
    logic          pix_clr;
    logic          wvalid;
    logic          wready = 1'b0;
    logic [WW-1:0] wdata;

    // matrix emulator state (owned by the negedge process)
    logic [NM-1:0] flag = '0;
    logic [NM-1:0] pend_model = '0;
    logic [15:0]   pix_m [NM];
    logic [7:0]    exp_ts [NM];
    int            cyc = 0;

    // stimulus requests (owned by the main process)
    logic [NM-1:0] inj_mask = '0;
    logic          inj_go = 1'b0;
    logic [NM-1:0] drop_mask = '0;
    logic          drop_go = 1'b0;
    logic [15:0]   inj_bits [NM];
    int            rdy_mode = 0;

    // monitor (owned by the monitor process)
    logic [WW-1:0] got [1024];
    int            got_n = 0;
    int            en_cyc = 0;
    int            clr_cnt = 0;

    // expectations and counters (main process)
    logic [WW-1:0] exp_w [1024];
    int            exp_n = 0;
    int            n_chk = 0;
    int            n_err = 0;

    always #5 clk = ~clk;

    mpix_readout_ctrl #(.N_MP(NM), .TS_W(TW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mp_hit_i     (flag),
        .mp_rd_en_o   (rd_en),
        .col_sel_o    (col_sel),
        .pix_row_i    (pix_row),
        .pix_clr_o    (pix_clr),
        .word_valid_o (wvalid),
        .word_ready_i (wready),
        .word_data_o  (wdata)
    );

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    always_comb begin
        pix_row = '0;
        for (int m = 0; m < NM; m++)
            for (int c = 0; c < 4; c++)
                if (rd_en[m] && col_sel[c]) pix_row = pix_m[m][c*4 +: 4];
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            flag = '0;
            pend_model = '0;
            for (int m = 0; m < NM; m++) begin
                pix_m[m] = '0;
                exp_ts[m] = '0;
            end
        end else begin
            if (pix_clr)
                for (int m = 0; m < NM; m++)
                    if (rd_en[m]) begin
                        flag[m] = 1'b0;
                        pix_m[m] = '0;
                        pend_model[m] = 1'b0;
                    end
            if (drop_go) flag = flag & ~drop_mask;
            if (inj_go)
                for (int m = 0; m < NM; m++)
                    if (inj_mask[m]) begin
                        if (!pend_model[m]) begin
                            pend_model[m] = 1'b1;
                            exp_ts[m] = cyc[7:0];
                        end
                        flag[m] = 1'b1;
                        pix_m[m] = pix_m[m] | inj_bits[m];
                    end
        end
    end

    always @(posedge clk) begin
        #1;
        case (rdy_mode)
            0:       wready = 1'b0;
            1:       wready = 1'b1;
            default: wready = 1'($urandom_range(0, 1));
        endcase
    end

    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (wvalid && wready) begin
                got[got_n] = wdata;
                got_n = got_n + 1;
            end
            if (rd_en != '0) en_cyc = en_cyc + 1;
            if (pix_clr) clr_cnt = clr_cnt + 1;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err + 1, n_chk + 1);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic fire_inject(input logic [NM-1:0] mask);
        @(posedge clk); #1;
        inj_mask = mask;
        inj_go = 1'b1;
        @(negedge clk); #1;
        inj_go = 1'b0;
    endtask

    task automatic fire_drop(input logic [NM-1:0] mask);
        @(posedge clk); #1;
        drop_mask = mask;
        drop_go = 1'b1;
        @(negedge clk); #1;
        drop_go = 1'b0;
    endtask

    task automatic expect_mp(input int m, input logic [15:0] bits);
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                if (bits[c*4 + r]) begin
                    exp_w[exp_n] = {4'(m), 2'(c), 2'(r), exp_ts[m]};
                    exp_n++;
                end
    endtask

    task automatic drain();
        int quiet = 0;
        for (int k = 0; k < 5000 && quiet < 3; k++) begin
            @(negedge clk); #3;
            if (pend_model == '0 && rd_en == '0 && !wvalid) quiet++;
            else quiet = 0;
        end
    endtask

    task automatic compare(input int base, input string tag);
        int n = got_n - base;
        check(n == exp_n, {tag, " word count"}, 32'(n), 32'(exp_n));
        for (int i = 0; i < exp_n && i < n; i++)
            check(got[base + i] === exp_w[i], {tag, " word"}, 32'(got[base + i]), 32'(exp_w[i]));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        check(rd_en == '0 && col_sel == '0, "R1 enables in reset", {rd_en, 12'h0, col_sel}, 0);
        check(!wvalid && !pix_clr, "R1 valid/clear in reset", {wvalid, pix_clr}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        check(rd_en == '0 && !wvalid && !pix_clr && col_sel == '0, "R1 outputs after reset",
              {rd_en, wvalid, pix_clr, col_sel}, 0);
    endtask

    task automatic t_single();
        int base = got_n, e0 = en_cyc, c0 = clr_cnt;
        rdy_mode = 1;
        exp_n = 0;
        inj_bits[6] = 16'hE805;
        fire_inject(16'h0040);
        @(negedge clk); #2;
        check(rd_en == '0, "R3 no enable in pending cycle", 32'(rd_en), 0);
        @(negedge clk); #2;
        check(rd_en == 16'h0040, "R3 enable one cycle later", 32'(rd_en), 32'h40);
        check(col_sel == 4'b0001, "R6 first column select", 32'(col_sel), 1);
        expect_mp(6, 16'hE805);
        drain();
        compare(base, "R2 R7 R8 single");
        check(en_cyc - e0 == 8, "R6 enable cycles", 32'(en_cyc - e0), 8);
        check(clr_cnt - c0 == 1, "R10 clear pulses", 32'(clr_cnt - c0), 1);
    endtask

    task automatic t_empty();
        int base = got_n, e0 = en_cyc, c0 = clr_cnt;
        rdy_mode = 1;
        exp_n = 0;
        inj_bits[11] = 16'h0000;
        fire_inject(16'h0800);
        drain();
        compare(base, "R7 empty macropixel");
        check(en_cyc - e0 == 5, "R6 empty scan length", 32'(en_cyc - e0), 5);
        check(clr_cnt - c0 == 1, "R10 empty clear", 32'(clr_cnt - c0), 1);
    endtask

    task automatic t_prio_merge();
        int base = got_n, c0 = clr_cnt;
        logic [WW-1:0] held;
        logic [7:0] ts5;
        rdy_mode = 0;
        exp_n = 0;
        inj_bits[0] = 16'h0030;
        inj_bits[9] = 16'h0001;
        inj_bits[3] = 16'h8000;
        inj_bits[5] = 16'h0100;
        fire_inject(16'h0001);
        repeat (5) @(negedge clk);
        #2;
        held = {4'd0, 2'd1, 2'd0, exp_ts[0]};
        check(wvalid === 1'b1, "R9 valid held while stalled", 32'(wvalid), 1);
        check(wdata === held, "R9 word during stall", 32'(wdata), 32'(held));
        fire_inject(16'h0200);
        fire_inject(16'h0008);
        fire_inject(16'h0020);
        ts5 = exp_ts[5];
        fire_drop(16'h0020);
        repeat (2) @(negedge clk);
        inj_bits[5] = 16'h0200;
        fire_inject(16'h0020);
        repeat (3) @(negedge clk);
        #2;
        check(wvalid === 1'b1 && wdata === held, "R9 word unchanged after long stall", 32'(wdata), 32'(held));
        check(rd_en == 16'h0001, "R3 enable stays on stalled macropixel", 32'(rd_en), 1);
        check(exp_ts[5] == ts5, "R5 model kept first timestamp", 32'(exp_ts[5]), 32'(ts5));
        expect_mp(0, 16'h0030);
        expect_mp(3, 16'h8000);
        expect_mp(5, 16'h0300);
        expect_mp(9, 16'h0001);
        rdy_mode = 1;
        drain();
        compare(base, "R4 R5 priority and merge");
        check(clr_cnt - c0 == 4, "R5 one readout per macropixel", 32'(clr_cnt - c0), 4);
    endtask

    task automatic t_rehit();
        int base = got_n;
        logic [7:0] first_ts;
        rdy_mode = 1;
        exp_n = 0;
        inj_bits[2] = 16'h0001;
        fire_inject(16'h0004);
        expect_mp(2, 16'h0001);
        first_ts = exp_ts[2];
        drain();
        repeat (7) @(negedge clk);
        inj_bits[2] = 16'h0010;
        fire_inject(16'h0004);
        expect_mp(2, 16'h0010);
        drain();
        compare(base, "R10 rehit after release");
        check(exp_ts[2] != first_ts, "R10 fresh timestamp expected", 32'(exp_ts[2]), 32'(first_ts));
    endtask

    task automatic t_random();
        for (int round = 0; round < 8; round++) begin
            int base = got_n;
            logic [NM-1:0] mask;
            rdy_mode = 2;
            exp_n = 0;
            mask = NM'($urandom) | (NM'(1) << round);
            for (int m = 0; m < NM; m++)
                inj_bits[m] = ($urandom_range(0, 3) == 0) ? 16'h0000 : 16'($urandom);
            fire_inject(mask);
            for (int m = 0; m < NM; m++)
                if (mask[m]) expect_mp(m, inj_bits[m]);
            drain();
            compare(base, "R4 R7 R9 random round");
        end
    endtask

    initial begin
        for (int m = 0; m < NM; m++) inj_bits[m] = '0;
        t_reset();
        t_single();
        t_empty();
        t_prio_merge();
        t_rehit();
        t_random();
        repeat (4) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule